// File: doc/BRIEF.md
# Cascaded Bit-Slice Arithmetic Datapath

This block is the arithmetic core of a microprogrammed controller. It is built from identical narrow slices, two 4-bit slices by default, that together form an 8-bit word. The microinstruction fields are fanned out to every slice in parallel: the operand source code, the ALU function code, the destination code and the A and B register addresses. The carry line and the RAM and Q shift lines pass from one slice to the next, so the slices act as one word-wide unit.

Each slice holds a 16-word register file and a Q register. The register file has two read ports (A and B) and one write port at address B. The ALU combines a selected R/S operand pair and produces the result F. The destination code decides three things: which of F, F/2 or 2F is written back to the register file, what happens to Q, and whether F or the A word is driven on the three-state Y bus. At each end of the word, a shift-fill selector chooses the bit that enters the vacated position. The Carry, Sign and Zero flags come straight from the ALU, so they are valid whether or not Y is driven.

Top module: `bitslice_datapath`

## Requirements
- R1: Asynchronous reset (rstN low) clears all register-file words and Q to zero.
- R2: ALU function codes give F as follows: 0 = R+S+cin, 1 = S+~R+cin, 2 = R+~S+cin, 3 = R OR S, 4 = R AND S, 5 = (NOT R) AND S, 6 = R XOR S, 7 = R XNOR S. All results are taken modulo 2^8.
- R3: Source codes select the (R,S) pair as follows: 0 = (A,Q), 1 = (A,B), 2 = (0,Q), 3 = (0,B), 4 = (0,A), 5 = (D,A), 6 = (D,Q), 7 = (D,0). A and B are the register words at aAddr and bAddr, and D is dIn.
- R4: carryIn affects only function codes 0 to 2. For those codes, carryFlag is bit 8 of the 9-bit sum. For the logic codes 3 to 7, F does not depend on carryIn and carryFlag is 0.
- R5: signFlag equals F bit 7 and zeroFlag is 1 exactly when F is zero. Both flags are valid whether outEn is high or low.
- R6: Destination codes without a shift behave as follows. 0 loads F into Q. 1 changes no state. 2 writes F to word B and drives the A word on Y. 3 writes F to word B. Every destination code except 2 drives F on Y.
- R7: Destination code 4 writes F shifted right by one into word B and shifts Q right by one, both in the same clock. Destination code 5 performs only the register-file part. In each case the fill bit enters bit 7.
- R8: Destination code 6 writes F shifted left by one into word B and shifts Q left by one. Destination code 7 performs only the register-file part. In each case the fill bit enters bit 0.
- R9: shiftCode selects the fill bit as follows. 0 = constant 0. 1 = constant 1. 2 = the bit shifted out of the same shifter, which is F bit 0 or 7 for the RAM side and Q bit 0 or 7 for the Q side. 3 = the bit shifted out of the other shifter, which links the RAM side and Q into one double-length shift.
- R10: When shiftQual is 1, the Q-side fill bit is 0 whatever shiftCode is. The RAM-side fill still follows shiftCode.
- R11: The carry and the shifted bits cross the slice boundary. The 8-bit F, carry and shift results therefore equal those of a single 8-bit unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 3 | Operand source code |
| aluFunc | input | 3 | ALU function code |
| destSel | input | 3 | Destination and shift code |
| aAddr | input | 4 | Register-file A read address |
| bAddr | input | 4 | Register-file B read and write address |
| dIn | input | 8 | External data operand D |
| carryIn | input | 1 | Carry into the lowest slice |
| shiftCode | input | 2 | Shift-fill selector |
| shiftQual | input | 1 | Forces the Q-side fill to zero when 1 |
| outEn | input | 1 | Drives Y when 1; Y is high impedance when 0 |
| yOut | output | 8 | Three-state result bus |
| carryFlag | output | 1 | Carry out of the top slice |
| signFlag | output | 1 | Most significant bit of F |
| zeroFlag | output | 1 | F equals zero |

## Verification
The shift assertions assume that destination and address inputs stay steady across each rising edge. This is what lets each write be related to the F and fill bit of the cycle before. The bench meets this by changing inputs only at falling edges and by holding the no-op destination while reset is active, so no write is pending when reset releases. The operand sweeps use known register and Q contents that are loaded through the datapath itself. These contents include values whose carry or shifted bit crosses the slice boundary, so the cascade wiring is exercised by ordinary operations.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_DOWN = 2'd1,
    SH_UP   = 2'd2
  } shift_e;

  localparam logic [1:0] FILL_ZERO  = 2'd0;
  localparam logic [1:0] FILL_ONE   = 2'd1;
  localparam logic [1:0] FILL_OWN   = 2'd2;
  localparam logic [1:0] FILL_CROSS = 2'd3;

  localparam logic [1:0] RSRC_A = 2'd0;
  localparam logic [1:0] RSRC_D = 2'd1;
  localparam logic [1:0] RSRC_0 = 2'd2;

  localparam logic [1:0] SSRC_A = 2'd0;
  localparam logic [1:0] SSRC_B = 2'd1;
  localparam logic [1:0] SSRC_Q = 2'd2;
  localparam logic [1:0] SSRC_0 = 2'd3;

  typedef struct packed {
    logic       ramWe;
    logic       qWe;
    shift_e     ramShift;
    shift_e     qShift;
    logic       yFromA;
    logic [1:0] rSel;
    logic [1:0] sSel;
    logic [2:0] aluOp;
    logic [1:0] ramFill;
    logic [1:0] qFill;
  } strobe_t;

endpackage

// File: rtl/bsd_ctrl.sv
module bsd_ctrl
  import bsd_pkg::*;
(
  input  logic [2:0] srcSel,
  input  logic [2:0] aluFunc,
  input  logic [2:0] destSel,
  input  logic [1:0] shiftCode,
  input  logic       shiftQual,
  output strobe_t    st
);

  always_comb begin
    st          = '0;
    st.aluOp    = aluFunc;
    st.ramFill  = shiftCode;
    st.qFill    = shiftQual ? FILL_ZERO : shiftCode;
    st.ramShift = SH_NONE;
    st.qShift   = SH_NONE;

    case (srcSel)
      3'd0:    begin st.rSel = RSRC_A; st.sSel = SSRC_Q; end
      3'd1:    begin st.rSel = RSRC_A; st.sSel = SSRC_B; end
      3'd2:    begin st.rSel = RSRC_0; st.sSel = SSRC_Q; end
      3'd3:    begin st.rSel = RSRC_0; st.sSel = SSRC_B; end
      3'd4:    begin st.rSel = RSRC_0; st.sSel = SSRC_A; end
      3'd5:    begin st.rSel = RSRC_D; st.sSel = SSRC_A; end
      3'd6:    begin st.rSel = RSRC_D; st.sSel = SSRC_Q; end
      default: begin st.rSel = RSRC_D; st.sSel = SSRC_0; end
    endcase

    case (destSel)
      3'd0: st.qWe = 1'b1;
      3'd1: ;
      3'd2: begin st.ramWe = 1'b1; st.yFromA = 1'b1; end
      3'd3: st.ramWe = 1'b1;
      3'd4: begin
        st.ramWe = 1'b1; st.ramShift = SH_DOWN;
        st.qWe   = 1'b1; st.qShift   = SH_DOWN;
      end
      3'd5: begin st.ramWe = 1'b1; st.ramShift = SH_DOWN; end
      3'd6: begin
        st.ramWe = 1'b1; st.ramShift = SH_UP;
        st.qWe   = 1'b1; st.qShift   = SH_UP;
      end
      default: begin st.ramWe = 1'b1; st.ramShift = SH_UP; end
    endcase
  end

endmodule

// File: rtl/bsd_slice.sv
module bsd_slice
  import bsd_pkg::*;
#(
  parameter  int SW    = 4,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [AW-1:0] aAddr,
  input  logic [AW-1:0] bAddr,
  input  logic [SW-1:0] d,
  input  logic          cin,
  input  logic          ramDnIn,
  input  logic          ramUpIn,
  input  logic          qDnIn,
  input  logic          qUpIn,
  output logic [SW-1:0] f,
  output logic          cout,
  output logic [SW-1:0] aData,
  output logic [SW-1:0] qData
);

  logic [SW-1:0] mem [DEPTH];
  logic [SW-1:0] qReg;
  logic [SW-1:0] bData, rOp, sOp, ramNext, qNext;
  logic [SW:0]   sum;
  logic [SW:0]   cinW;

  assign aData = mem[aAddr];
  assign bData = mem[bAddr];
  assign qData = qReg;
  assign cinW  = {{SW{1'b0}}, cin};

  always_comb begin
    case (st.rSel)
      RSRC_A:  rOp = aData;
      RSRC_D:  rOp = d;
      default: rOp = '0;
    endcase
    case (st.sSel)
      SSRC_A:  sOp = aData;
      SSRC_B:  sOp = bData;
      SSRC_Q:  sOp = qReg;
      default: sOp = '0;
    endcase
  end

  always_comb begin
    case (st.aluOp)
      3'd0:    sum = {1'b0, rOp} + {1'b0, sOp} + cinW;
      3'd1:    sum = {1'b0, sOp} + {1'b0, ~rOp} + cinW;
      3'd2:    sum = {1'b0, rOp} + {1'b0, ~sOp} + cinW;
      3'd3:    sum = {1'b0, rOp | sOp};
      3'd4:    sum = {1'b0, rOp & sOp};
      3'd5:    sum = {1'b0, ~rOp & sOp};
      3'd6:    sum = {1'b0, rOp ^ sOp};
      default: sum = {1'b0, ~(rOp ^ sOp)};
    endcase
  end

  assign f    = sum[SW-1:0];
  assign cout = sum[SW];

  always_comb begin
    case (st.ramShift)
      SH_DOWN: ramNext = {ramDnIn, f[SW-1:1]};
      SH_UP:   ramNext = {f[SW-2:0], ramUpIn};
      default: ramNext = f;
    endcase
    case (st.qShift)
      SH_DOWN: qNext = {qDnIn, qReg[SW-1:1]};
      SH_UP:   qNext = {qReg[SW-2:0], qUpIn};
      default: qNext = f;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      qReg <= '0;
    end else begin
      if (st.ramWe) mem[bAddr] <= ramNext;
      if (st.qWe)   qReg <= qNext;
    end
  end

  AST_RAM_DOWN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (st.ramWe && st.ramShift == SH_DOWN) |=>
      mem[$past(bAddr)] == {$past(ramDnIn), $past(f[SW-1:1])}); // R7

  AST_RAM_UP_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (st.ramWe && st.ramShift == SH_UP) |=>
      mem[$past(bAddr)] == {$past(f[SW-2:0]), $past(ramUpIn)}); // R8

  AST_Q_DOWN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (st.qWe && st.qShift == SH_DOWN) |=>
      qReg == {$past(qDnIn), $past(qReg[SW-1:1])}); // R7

  AST_Q_LOAD_F: assert property (@(posedge clk) disable iff (!rstN)
    (st.qWe && st.qShift == SH_NONE) |=> qReg == $past(f)); // R6

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (st.aluOp >= 3'd3) |-> !cout); // R4

endmodule

// File: rtl/bsd_datapath.sv
module bsd_datapath
  import bsd_pkg::*;
#(
  parameter  int SW    = 4,
  parameter  int NS    = 2,
  parameter  int DEPTH = 16,
  localparam int W     = SW * NS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [AW-1:0] aAddr,
  input  logic [AW-1:0] bAddr,
  input  logic [W-1:0]  dIn,
  input  logic          carryIn,
  output logic [W-1:0]  fWord,
  output logic [W-1:0]  aWord,
  output logic          carryOut
);

  logic [NS:0]  carry;
  logic [W-1:0] qWord;
  logic ramTopFill, ramBotFill, qTopFill, qBotFill;

  assign carry[0] = carryIn;
  assign carryOut = carry[NS];

  always_comb begin
    case (st.ramFill)
      FILL_ZERO: begin ramTopFill = 1'b0;     ramBotFill = 1'b0;       end
      FILL_ONE:  begin ramTopFill = 1'b1;     ramBotFill = 1'b1;       end
      FILL_OWN:  begin ramTopFill = fWord[0]; ramBotFill = fWord[W-1]; end
      default:   begin ramTopFill = qWord[0]; ramBotFill = qWord[W-1]; end
    endcase
    case (st.qFill)
      FILL_ZERO: begin qTopFill = 1'b0;     qBotFill = 1'b0;       end
      FILL_ONE:  begin qTopFill = 1'b1;     qBotFill = 1'b1;       end
      FILL_OWN:  begin qTopFill = qWord[0]; qBotFill = qWord[W-1]; end
      default:   begin qTopFill = fWord[0]; qBotFill = fWord[W-1]; end
    endcase
  end

  for (genvar i = 0; i < NS; i++) begin : gSlice
    logic ramDn, ramUp, qDn, qUp;

    if (i == NS - 1) begin : gTop
      assign ramDn = ramTopFill;
      assign qDn   = qTopFill;
    end else begin : gMidTop
      assign ramDn = fWord[(i+1)*SW];
      assign qDn   = qWord[(i+1)*SW];
    end

    if (i == 0) begin : gBot
      assign ramUp = ramBotFill;
      assign qUp   = qBotFill;
    end else begin : gMidBot
      assign ramUp = fWord[i*SW-1];
      assign qUp   = qWord[i*SW-1];
    end

    bsd_slice #(.SW(SW), .DEPTH(DEPTH)) uSlice (
      .clk     (clk),
      .rstN    (rstN),
      .st      (st),
      .aAddr   (aAddr),
      .bAddr   (bAddr),
      .d       (dIn[i*SW +: SW]),
      .cin     (carry[i]),
      .ramDnIn (ramDn),
      .ramUpIn (ramUp),
      .qDnIn   (qDn),
      .qUpIn   (qUp),
      .f       (fWord[i*SW +: SW]),
      .cout    (carry[i+1]),
      .aData   (aWord[i*SW +: SW]),
      .qData   (qWord[i*SW +: SW])
    );
  end

  AST_Q_FILL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (st.qWe && st.qShift == SH_DOWN && st.qFill == FILL_ZERO) |=>
      !qWord[W-1]); // R10

  AST_Q_UP_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    (st.qWe && st.qShift == SH_UP) |=>
      qWord[SW] == $past(qWord[SW-1])); // R11

endmodule

// File: rtl/bitslice_datapath.sv
module bitslice_datapath
  import bsd_pkg::*;
#(
  parameter  int SLICE_W    = 4,
  parameter  int NUM_SLICES = 2,
  parameter  int REG_DEPTH  = 16,
  localparam int W          = SLICE_W * NUM_SLICES,
  localparam int AW         = $clog2(REG_DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    srcSel,
  input  logic [2:0]    aluFunc,
  input  logic [2:0]    destSel,
  input  logic [AW-1:0] aAddr,
  input  logic [AW-1:0] bAddr,
  input  logic [W-1:0]  dIn,
  input  logic          carryIn,
  input  logic [1:0]    shiftCode,
  input  logic          shiftQual,
  input  logic          outEn,
  output logic [W-1:0]  yOut,
  output logic          carryFlag,
  output logic          signFlag,
  output logic          zeroFlag
);

  strobe_t      st;
  logic [W-1:0] fWord, aWord;

  bsd_ctrl uCtrl (
    .srcSel    (srcSel),
    .aluFunc   (aluFunc),
    .destSel   (destSel),
    .shiftCode (shiftCode),
    .shiftQual (shiftQual),
    .st        (st)
  );

  bsd_datapath #(.SW(SLICE_W), .NS(NUM_SLICES), .DEPTH(REG_DEPTH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .aAddr    (aAddr),
    .bAddr    (bAddr),
    .dIn      (dIn),
    .carryIn  (carryIn),
    .fWord    (fWord),
    .aWord    (aWord),
    .carryOut (carryFlag)
  );

  assign signFlag = fWord[W-1];
  assign zeroFlag = (fWord == '0);
  assign yOut     = outEn ? (st.yFromA ? aWord : fWord) : {W{1'bz}};

  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rstN)
    zeroFlag |-> !signFlag); // R5

endmodule

// File: tb/sim_bitslice_datapath.sv
module sim_bitslice_datapath;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] srcSel = 3'd0, aluFunc = 3'd3, destSel = 3'd1;
  logic [3:0] aAddr = '0, bAddr = '0;
  logic [7:0] dIn = '0;
  logic       carryIn = 1'b0;
  logic [1:0] shiftCode = '0;
  logic       shiftQual = 1'b0;
  logic       outEn = 1'b1;
  logic [7:0] yOut;
  logic       carryFlag, signFlag, zeroFlag;

  int  nChecks = 0;
  int  nErr    = 0;
  bit  done    = 0;

  logic [7:0] mReg [16];
  logic [7:0] mQ;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitslice_datapath u0 (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .aluFunc(aluFunc),
    .destSel(destSel), .aAddr(aAddr), .bAddr(bAddr), .dIn(dIn),
    .carryIn(carryIn), .shiftCode(shiftCode), .shiftQual(shiftQual),
    .outEn(outEn), .yOut(yOut), .carryFlag(carryFlag),
    .signFlag(signFlag), .zeroFlag(zeroFlag)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] src, input logic [2:0] fn,
                      input logic [2:0] dst, input logic [3:0] a,
                      input logic [3:0] b, input logic [7:0] d,
                      input logic ci, input logic [1:0] code,
                      input logic qual, input logic oe, input bit check,
                      input string tag);
    logic [7:0] r, s, f, yExp;
    logic [8:0] t;
    logic c, ramDn, ramUp, qDn, qUp;
    case (src)
      3'd0, 3'd1: r = mReg[a];
      3'd2, 3'd3, 3'd4: r = 8'h00;
      default: r = d;
    endcase
    case (src)
      3'd0, 3'd2, 3'd6: s = mQ;
      3'd1, 3'd3: s = mReg[b];
      3'd4, 3'd5: s = mReg[a];
      default: s = 8'h00;
    endcase
    case (fn)
      3'd0: t = {1'b0, r} + {1'b0, s} + {8'h00, ci};
      3'd1: t = {1'b0, s} + {1'b0, ~r} + {8'h00, ci};
      3'd2: t = {1'b0, r} + {1'b0, ~s} + {8'h00, ci};
      3'd3: t = {1'b0, r | s};
      3'd4: t = {1'b0, r & s};
      3'd5: t = {1'b0, ~r & s};
      3'd6: t = {1'b0, r ^ s};
      default: t = {1'b0, ~(r ^ s)};
    endcase
    f = t[7:0];
    c = t[8];
    yExp = (dst == 3'd2) ? mReg[a] : f;
    case (code)
      2'd0: begin ramDn = 0; ramUp = 0; qDn = 0; qUp = 0; end
      2'd1: begin ramDn = 1; ramUp = 1; qDn = 1; qUp = 1; end
      2'd2: begin ramDn = f[0]; ramUp = f[7]; qDn = mQ[0]; qUp = mQ[7]; end
      default: begin ramDn = mQ[0]; ramUp = mQ[7]; qDn = f[0]; qUp = f[7]; end
    endcase
    if (qual) begin qDn = 0; qUp = 0; end

    @(negedge clk);
    srcSel = src; aluFunc = fn; destSel = dst; aAddr = a; bAddr = b;
    dIn = d; carryIn = ci; shiftCode = code; shiftQual = qual; outEn = oe;
    #1;
    if (check) begin
      if (oe) chk({tag, " y"}, {1'b0, yOut}, {1'b0, yExp});
      chk({tag, " carry R4"}, {8'h00, carryFlag}, {8'h00, c});
      chk({tag, " sign R5"}, {8'h00, signFlag}, {8'h00, f[7]});
      chk({tag, " zero R5"}, {8'h00, zeroFlag}, {8'h00, (f == 8'h00)});
    end
    @(posedge clk);
    case (dst)
      3'd0: mQ = f;
      3'd2, 3'd3: mReg[b] = f;
      3'd4: begin mReg[b] = {ramDn, f[7:1]}; mQ = {qDn, mQ[7:1]}; end
      3'd5: mReg[b] = {ramDn, f[7:1]};
      3'd6: begin mReg[b] = {f[6:0], ramUp}; mQ = {mQ[6:0], qUp}; end
      3'd7: mReg[b] = {f[6:0], ramUp};
      default: ;
    endcase
  endtask

  task automatic writeReg(input logic [3:0] b, input logic [7:0] v);
    doOp(3'd7, 3'd3, 3'd3, 4'd0, b, v, 1'b0, 2'd0, 1'b0, 1'b1, 0, "wr");
  endtask

  task automatic writeQ(input logic [7:0] v);
    doOp(3'd7, 3'd3, 3'd0, 4'd0, 4'd0, v, 1'b0, 2'd0, 1'b0, 1'b1, 0, "wq");
  endtask

  task automatic readReg(input logic [3:0] a, input string tag);
    @(negedge clk);
    srcSel = 3'd4; aluFunc = 3'd3; destSel = 3'd1; aAddr = a; outEn = 1'b1;
    #1;
    chk({tag, " reg readback"}, {1'b0, yOut}, {1'b0, mReg[a]});
  endtask

  task automatic readQ(input string tag);
    @(negedge clk);
    srcSel = 3'd2; aluFunc = 3'd3; destSel = 3'd1; outEn = 1'b1;
    #1;
    chk({tag, " q readback"}, {1'b0, yOut}, {1'b0, mQ});
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [7:0] aVal [3];
    logic [7:0] bVal [3];
    logic [7:0] qVal [3];
    logic [7:0] dVal [3];
    logic [7:0] dPat [2];
    logic [7:0] qPat [2];
    string tg;
    aVal = '{8'h0F, 8'h00, 8'hA5};
    bVal = '{8'h01, 8'hFF, 8'h5A};
    qVal = '{8'hF0, 8'h80, 8'h33};
    dVal = '{8'h81, 8'h7F, 8'hC8};
    dPat = '{8'h13, 8'hEC};
    qPat = '{8'h84, 8'h7B};
    for (int i = 0; i < 16; i++) mReg[i] = 8'hFF;
    mQ = 8'hFF;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) mReg[i] = 8'h00;
    mQ = 8'h00;

    // R1: cleared state after reset
    readReg(4'd0, "R1");
    readReg(4'd7, "R1");
    readReg(4'd15, "R1");
    readQ("R1");

    // R2 R3 R4 R5: function x source x carry sweep; set 2 runs with Y off
    for (int k = 0; k < 3; k++) begin
      writeReg(4'd3, aVal[k]);
      writeReg(4'd9, bVal[k]);
      writeQ(qVal[k]);
      for (int fn = 0; fn < 8; fn++)
        for (int src = 0; src < 8; src++)
          for (int ci = 0; ci < 2; ci++)
            doOp(3'(src), 3'(fn), 3'd1, 4'd3, 4'd9, dVal[k], 1'(ci),
                 2'd0, 1'b0, (k != 2), 1, "R2/R3");
    end

    // R11: carry ripple and borrow across the slice boundary
    writeReg(4'd3, 8'h0F);
    writeReg(4'd9, 8'h01);
    doOp(3'd1, 3'd0, 3'd1, 4'd3, 4'd9, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 1, "R11 add");
    doOp(3'd1, 3'd0, 3'd1, 4'd9, 4'd9, 8'h00, 1'b1, 2'd0, 1'b0, 1'b1, 1, "R11 add");
    doOp(3'd5, 3'd2, 3'd1, 4'd3, 4'd9, 8'h10, 1'b1, 2'd0, 1'b0, 1'b1, 1, "R11 sub");
    doOp(3'd5, 3'd0, 3'd1, 4'd3, 4'd9, 8'hF1, 1'b0, 2'd0, 1'b0, 1'b1, 1, "R11 wrap");

    // R6 R7 R8 R9 R10: destination x fill code x qualifier
    for (int p = 0; p < 2; p++)
      for (int dst = 0; dst < 8; dst++)
        for (int code = 0; code < 4; code++)
          for (int qual = 0; qual < 2; qual++) begin
            if (dst < 4) tg = "R6";
            else if (dst < 6) tg = "R7 R9 R10 R11";
            else tg = "R8 R9 R10";
            writeReg(4'd5, 8'h3C);
            writeReg(4'd2, 8'hC6);
            writeQ(qPat[p]);
            doOp(3'd7, 3'd3, 3'(dst), 4'd2, 4'd5, dPat[p], 1'b0,
                 2'(code), 1'(qual), 1'b1, 1, tg);
            readReg(4'd5, tg);
            readReg(4'd2, tg);
            readQ(tg);
          end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule